// File: doc/BRIEF.md
# Processor Exception Vector Dispatcher

This block sits beside a small CPU core and turns an exception request or a debug event into the architectural state changes that must happen before the core jumps to a handler. In the cycle a request is sampled it decides which handler vector applies and saves the current PC into the right save register. It records the cause code and, when the fault involves an address, the faulting virtual address. It also produces the new processor-status word the core must load. A one-hot vector select and a single-cycle valid pulse tell the fetch logic where to go. Fetching from the vector, flushing the pipeline and the vector addresses themselves are handled elsewhere.

A general exception picks between three vectors. A fault raised while the core is already handling an exception goes to the double-exception vector and uses its own PC save register. Otherwise the core's privilege bit selects the user or the kernel vector. A debug event is accepted only when the core's current interrupt level is below the configured debug level. An accepted debug event stores the PC and the old status word in the slots belonging to that level, and raises the interrupt level to the debug level.

Requests are plain single-cycle strobes with no back-pressure: a request is consumed on the clock edge that samples it, and a new request may arrive on every cycle. The status word layout used here places the interrupt level in bits [3:0], the exception-mode flag in bit 4 and the user-mode flag in bit 5. All other status bits are carried through unchanged.

Top module: `exc_vector_dispatch`

## Requirements
- R1: After reset, vec_valid and vec_sel are 0, and every saved register output (ps_out, epc_o, depc_o, eps_o, exccause_o, excvaddr_o, debugcause_o) is 0.
- R2: A general exception with ps_in bit 4 (exception mode) clear and bit 5 (user mode) clear selects the kernel vector (vec_sel = 4'b0001) and stores cur_pc in EPC slot 1 (epc_o bits [31:0]).
- R3: A general exception with ps_in bit 4 clear and bit 5 set selects the user vector (vec_sel = 4'b0010) and stores cur_pc in EPC slot 1.
- R4: A general exception with ps_in bit 4 already set selects the double vector (vec_sel = 4'b0100). With HAS_DEPC = 1 (default) cur_pc goes to depc_o and EPC slot 1 is left unchanged; with HAS_DEPC = 0 it goes to EPC slot 1.
- R5: On every general exception exccause_o takes exc_cause_i, and ps_out equals ps_in with bit 4 set and all other bits unchanged.
- R6: On a general exception, exc_addr_src = 1 loads excvaddr_o from fetch_addr (instruction-side faults), 2 loads it from data_addr (load/store faults), and 0 or 3 leave excvaddr_o unchanged.
- R7: A debug event is taken only when ps_in[3:0] < DEBUG_LEVEL. A debug request with ps_in[3:0] >= DEBUG_LEVEL and no exception has no effect: vec_valid stays 0 and all register outputs hold.
- R8: A taken debug event selects the debug vector (vec_sel = 4'b1000). It sets debugcause_o to dbg_cause_i, stores cur_pc in EPC slot DEBUG_LEVEL and ps_in in EPS slot DEBUG_LEVEL. It sets ps_out to ps_in with bits [3:0] = DEBUG_LEVEL and bit 4 set, and leaves exccause_o unchanged.
- R9: When a taken debug event and a general exception arrive in the same cycle, the debug event wins and the exception leaves no trace (exccause_o, excvaddr_o and EPC slot 1 unchanged). If the debug request is gated off by R7, the exception is dispatched normally.
- R10: All updates for one request become visible together after the clock edge that samples it. vec_valid is high for exactly that one cycle, and with no request the register outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_pc | input | XLEN | PC of the instruction raising the event |
| ps_in | input | XLEN | Current processor-status word |
| exc_valid | input | 1 | General exception request strobe |
| exc_cause_i | input | CAUSE_W | Exception cause code |
| exc_addr_src | input | 2 | Faulting-address source: 0 none, 1 fetch, 2 data, 3 none |
| fetch_addr | input | XLEN | Instruction-side faulting address |
| data_addr | input | XLEN | Load/store faulting address |
| dbg_valid | input | 1 | Debug event request strobe |
| dbg_cause_i | input | DCAUSE_W | Debug cause code |
| vec_valid | output | 1 | One-cycle pulse: a vector was chosen |
| vec_sel | output | 4 | One-hot vector: bit0 kernel, bit1 user, bit2 double, bit3 debug |
| ps_out | output | XLEN | New status word for the core to load |
| epc_o | output | DEBUG_LEVEL*XLEN | EPC slots 1..DEBUG_LEVEL, slot k at bits [k*XLEN-1 -: XLEN] |
| depc_o | output | XLEN | Double-exception PC save |
| eps_o | output | (DEBUG_LEVEL-1)*XLEN | EPS slots 2..DEBUG_LEVEL, slot k at bits [(k-1)*XLEN-1 -: XLEN] |
| exccause_o | output | CAUSE_W | Last exception cause |
| excvaddr_o | output | XLEN | Last faulting virtual address |
| debugcause_o | output | DCAUSE_W | Last debug cause |

## Verification
The dispatch path is driven with status words covering each exception-mode and user-mode combination, so that kernel, user and double vectors are each told apart. The untouched status bit 8 is set to show that non-control bits pass through. Address capture is tried with fetch, data and no-address sources to separate the three behaviours of EXCVADDR. Debug requests are applied at interrupt levels one below, equal to and above the debug level, which pins down the strict comparison. They are also applied together with exceptions, so that priority and the gated-debug fall-through are each seen in isolation.

// File: rtl/exc_dispatch_pkg.sv
package exc_dispatch_pkg;

  // Status word field positions (the core decodes these)
  localparam int PS_ILVL_LSB = 0;
  localparam int PS_ILVL_W   = 4;
  localparam int PS_EXCM_BIT = 4;
  localparam int PS_UM_BIT   = 5;

  localparam int NUM_VEC = 4;

  typedef enum logic [1:0] {
    VEC_KERNEL = 2'd0,
    VEC_USER   = 2'd1,
    VEC_DOUBLE = 2'd2,
    VEC_DEBUG  = 2'd3
  } vec_e;

  typedef enum logic [1:0] {
    ASRC_NONE  = 2'd0,
    ASRC_FETCH = 2'd1,
    ASRC_DATA  = 2'd2,
    ASRC_RSVD  = 2'd3
  } addr_src_e;

  typedef enum logic [1:0] {
    ACT_IDLE    = 2'd0,
    ACT_GENERAL = 2'd1,
    ACT_DEBUG   = 2'd2
  } act_e;

  typedef struct packed {
    act_e act;
    vec_e vec;
    logic pc_to_depc;
  } route_t;

endpackage

// File: rtl/exc_dbg_gate.sv
module exc_dbg_gate #(
  parameter int DEBUG_LEVEL = 6,
  parameter int ILVL_W      = 4
) (
  input  logic              dbg_req,
  input  logic [ILVL_W-1:0] cur_ilvl,
  output logic              dbg_take
);
  localparam logic [ILVL_W-1:0] LVL_LIMIT = ILVL_W'(DEBUG_LEVEL);

  // strictly-below comparison: equal level masks the event
  always_comb begin
    dbg_take = dbg_req && (cur_ilvl < LVL_LIMIT);
  end
endmodule

// File: rtl/exc_route.sv
module exc_route
  import exc_dispatch_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int DEBUG_LEVEL = 6,
  parameter bit HAS_DEPC    = 1'b1
) (
  input  logic            exc_req,
  input  logic            dbg_take,
  input  logic [XLEN-1:0] ps_cur,
  output route_t          route,
  output logic [XLEN-1:0] ps_next
);
  localparam logic [PS_ILVL_W-1:0] DBG_LVL_V = PS_ILVL_W'(DEBUG_LEVEL);

  logic in_exc;
  logic user_mode;

  assign in_exc    = ps_cur[PS_EXCM_BIT];
  assign user_mode = ps_cur[PS_UM_BIT];

  always_comb begin
    route.act        = ACT_IDLE;
    route.vec        = VEC_KERNEL;
    route.pc_to_depc = 1'b0;
    ps_next          = ps_cur;

    if (dbg_take) begin
      route.act = ACT_DEBUG;
      route.vec = VEC_DEBUG;
      ps_next[PS_ILVL_LSB +: PS_ILVL_W] = DBG_LVL_V;
      ps_next[PS_EXCM_BIT] = 1'b1;
    end else if (exc_req) begin
      route.act = ACT_GENERAL;
      if (in_exc) begin
        route.vec        = VEC_DOUBLE;
        route.pc_to_depc = HAS_DEPC;
      end else if (user_mode) begin
        route.vec = VEC_USER;
      end else begin
        route.vec = VEC_KERNEL;
      end
      ps_next[PS_EXCM_BIT] = 1'b1;
    end
  end
endmodule

// File: rtl/exc_sreg_bank.sv
module exc_sreg_bank
  import exc_dispatch_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int DEBUG_LEVEL = 6,
  parameter int CAUSE_W     = 6,
  parameter int DCAUSE_W    = 6
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  route_t                          route,
  input  logic [XLEN-1:0]                 ps_next,
  input  logic [XLEN-1:0]                 ps_cur,
  input  logic [XLEN-1:0]                 pc,
  input  logic [CAUSE_W-1:0]              cause,
  input  logic [DCAUSE_W-1:0]             dcause,
  input  logic [1:0]                      addr_src,
  input  logic [XLEN-1:0]                 fetch_addr,
  input  logic [XLEN-1:0]                 data_addr,
  output logic                            vec_valid,
  output logic [NUM_VEC-1:0]              vec_sel,
  output logic [XLEN-1:0]                 ps_q,
  output logic [DEBUG_LEVEL*XLEN-1:0]     epc_flat,
  output logic [XLEN-1:0]                 depc_q,
  output logic [(DEBUG_LEVEL-1)*XLEN-1:0] eps_flat,
  output logic [CAUSE_W-1:0]              cause_q,
  output logic [XLEN-1:0]                 vaddr_q,
  output logic [DCAUSE_W-1:0]             dcause_q
);
  logic is_gen;
  logic is_dbg;

  assign is_gen = (route.act == ACT_GENERAL);
  assign is_dbg = (route.act == ACT_DEBUG);

  // vector pulse and status word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec_sel   <= '0;
      ps_q      <= '0;
    end else begin
      vec_valid <= is_gen || is_dbg;
      vec_sel   <= (is_gen || is_dbg) ? (NUM_VEC'(1) << route.vec) : '0;
      if (is_gen || is_dbg) begin
        ps_q <= ps_next;
      end
    end
  end

  // general-exception records
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      vaddr_q <= '0;
      depc_q  <= '0;
    end else if (is_gen) begin
      cause_q <= cause;
      if (route.pc_to_depc) begin
        depc_q <= pc;
      end
      case (addr_src)
        ASRC_FETCH: vaddr_q <= fetch_addr;
        ASRC_DATA:  vaddr_q <= data_addr;
        default:    vaddr_q <= vaddr_q;
      endcase
    end
  end

  // debug cause
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcause_q <= '0;
    end else if (is_dbg) begin
      dcause_q <= dcause;
    end
  end

  // EPC slots 1..DEBUG_LEVEL
  for (genvar k = 1; k <= DEBUG_LEVEL; k++) begin : g_epc
    logic [XLEN-1:0] slot_q;
    logic            wr_gen;
    logic            wr_dbg;
    assign wr_gen = is_gen && (k == 1) && !route.pc_to_depc;
    assign wr_dbg = is_dbg && (k == DEBUG_LEVEL);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (wr_gen || wr_dbg) begin
        slot_q <= pc;
      end
    end
    assign epc_flat[k*XLEN-1 -: XLEN] = slot_q;
  end

  // EPS slots 2..DEBUG_LEVEL
  for (genvar k = 2; k <= DEBUG_LEVEL; k++) begin : g_eps
    logic [XLEN-1:0] slot_q;
    logic            wr_dbg;
    assign wr_dbg = is_dbg && (k == DEBUG_LEVEL);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (wr_dbg) begin
        slot_q <= ps_cur;
      end
    end
    assign eps_flat[(k-1)*XLEN-1 -: XLEN] = slot_q;
  end
endmodule

// File: rtl/exc_vector_dispatch.sv
module exc_vector_dispatch
  import exc_dispatch_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int DEBUG_LEVEL = 6,
  parameter int CAUSE_W     = 6,
  parameter int DCAUSE_W    = 6,
  parameter bit HAS_DEPC    = 1'b1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [XLEN-1:0]                 cur_pc,
  input  logic [XLEN-1:0]                 ps_in,
  input  logic                            exc_valid,
  input  logic [CAUSE_W-1:0]              exc_cause_i,
  input  logic [1:0]                      exc_addr_src,
  input  logic [XLEN-1:0]                 fetch_addr,
  input  logic [XLEN-1:0]                 data_addr,
  input  logic                            dbg_valid,
  input  logic [DCAUSE_W-1:0]             dbg_cause_i,
  output logic                            vec_valid,
  output logic [3:0]                      vec_sel,
  output logic [XLEN-1:0]                 ps_out,
  output logic [DEBUG_LEVEL*XLEN-1:0]     epc_o,
  output logic [XLEN-1:0]                 depc_o,
  output logic [(DEBUG_LEVEL-1)*XLEN-1:0] eps_o,
  output logic [CAUSE_W-1:0]              exccause_o,
  output logic [XLEN-1:0]                 excvaddr_o,
  output logic [DCAUSE_W-1:0]             debugcause_o
);
  logic            dbg_take;
  route_t          route;
  logic [XLEN-1:0] ps_next;

  exc_dbg_gate #(
    .DEBUG_LEVEL(DEBUG_LEVEL),
    .ILVL_W     (PS_ILVL_W)
  ) u_gate (
    .dbg_req (dbg_valid),
    .cur_ilvl(ps_in[PS_ILVL_LSB +: PS_ILVL_W]),
    .dbg_take(dbg_take)
  );

  exc_route #(
    .XLEN       (XLEN),
    .DEBUG_LEVEL(DEBUG_LEVEL),
    .HAS_DEPC   (HAS_DEPC)
  ) u_route (
    .exc_req (exc_valid),
    .dbg_take(dbg_take),
    .ps_cur  (ps_in),
    .route   (route),
    .ps_next (ps_next)
  );

  exc_sreg_bank #(
    .XLEN       (XLEN),
    .DEBUG_LEVEL(DEBUG_LEVEL),
    .CAUSE_W    (CAUSE_W),
    .DCAUSE_W   (DCAUSE_W)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .route     (route),
    .ps_next   (ps_next),
    .ps_cur    (ps_in),
    .pc        (cur_pc),
    .cause     (exc_cause_i),
    .dcause    (dbg_cause_i),
    .addr_src  (exc_addr_src),
    .fetch_addr(fetch_addr),
    .data_addr (data_addr),
    .vec_valid (vec_valid),
    .vec_sel   (vec_sel),
    .ps_q      (ps_out),
    .epc_flat  (epc_o),
    .depc_q    (depc_o),
    .eps_flat  (eps_o),
    .cause_q   (exccause_o),
    .vaddr_q   (excvaddr_o),
    .dcause_q  (debugcause_o)
  );
endmodule

// File: rtl/exc_dispatch_chk.sv
module exc_dispatch_chk #(
  parameter int XLEN        = 32,
  parameter int DEBUG_LEVEL = 6,
  parameter int CAUSE_W     = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               exc_valid,
  input logic               dbg_valid,
  input logic [XLEN-1:0]    ps_in,
  input logic [CAUSE_W-1:0] exc_cause_i,
  input logic               vec_valid,
  input logic [3:0]         vec_sel,
  input logic [XLEN-1:0]    ps_out,
  input logic [CAUSE_W-1:0] exccause_o
);
  localparam logic [3:0] LVL = 4'(DEBUG_LEVEL);
  logic dbg_ok;
  assign dbg_ok = dbg_valid && (ps_in[3:0] < LVL);

  AST_VEC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vec_sel) && (vec_valid == (vec_sel != 4'b0))); // R10

  AST_EXCM_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid || dbg_ok) |=> ps_out[4]); // R5

  AST_DOUBLE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && !dbg_ok && ps_in[4]) |=> (vec_sel == 4'b0100)); // R4

  AST_KERNEL_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && !dbg_ok && !ps_in[4] && !ps_in[5]) |=> (vec_sel == 4'b0001)); // R2

  AST_USER_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && !dbg_ok && !ps_in[4] && ps_in[5]) |=> (vec_sel == 4'b0010)); // R3

  AST_CAUSE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && !dbg_ok) |=> (exccause_o == $past(exc_cause_i))); // R5

  AST_DEBUG_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_valid && !dbg_ok && !exc_valid) |=> !vec_valid); // R7

  AST_DEBUG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_ok |=> (vec_sel == 4'b1000) && (ps_out[3:0] == LVL) && $stable(exccause_o)); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_valid && !dbg_valid) |=> !vec_valid && $stable(ps_out)); // R10
endmodule

bind exc_vector_dispatch exc_dispatch_chk #(
  .XLEN       (XLEN),
  .DEBUG_LEVEL(DEBUG_LEVEL),
  .CAUSE_W    (CAUSE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .exc_valid  (exc_valid),
  .dbg_valid  (dbg_valid),
  .ps_in      (ps_in),
  .exc_cause_i(exc_cause_i),
  .vec_valid  (vec_valid),
  .vec_sel    (vec_sel),
  .ps_out     (ps_out),
  .exccause_o (exccause_o)
);

// File: tb/tb_exc_vector_dispatch.sv
module tb_exc_vector_dispatch;
  localparam int XLEN = 32;
  localparam int LVL  = 6;
  localparam int CW   = 6;
  localparam int DCW  = 6;

  logic                     clk = 1'b0;
  logic                     rst_n = 1'b0;
  logic [XLEN-1:0]          cur_pc = '0;
  logic [XLEN-1:0]          ps_in = '0;
  logic                     exc_valid = 1'b0;
  logic [CW-1:0]            exc_cause_i = '0;
  logic [1:0]               exc_addr_src = '0;
  logic [XLEN-1:0]          fetch_addr = '0;
  logic [XLEN-1:0]          data_addr = '0;
  logic                     dbg_valid = 1'b0;
  logic [DCW-1:0]           dbg_cause_i = '0;
  logic                     vec_valid;
  logic [3:0]               vec_sel;
  logic [XLEN-1:0]          ps_out;
  logic [LVL*XLEN-1:0]      epc_o;
  logic [XLEN-1:0]          depc_o;
  logic [(LVL-1)*XLEN-1:0]  eps_o;
  logic [CW-1:0]            exccause_o;
  logic [XLEN-1:0]          excvaddr_o;
  logic [DCW-1:0]           debugcause_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  exc_vector_dispatch #(.XLEN(XLEN), .DEBUG_LEVEL(LVL), .CAUSE_W(CW), .DCAUSE_W(DCW)) dut (
    .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .ps_in(ps_in),
    .exc_valid(exc_valid), .exc_cause_i(exc_cause_i), .exc_addr_src(exc_addr_src),
    .fetch_addr(fetch_addr), .data_addr(data_addr), .dbg_valid(dbg_valid),
    .dbg_cause_i(dbg_cause_i), .vec_valid(vec_valid), .vec_sel(vec_sel),
    .ps_out(ps_out), .epc_o(epc_o), .depc_o(depc_o), .eps_o(eps_o),
    .exccause_o(exccause_o), .excvaddr_o(excvaddr_o), .debugcause_o(debugcause_o)
  );

  function automatic logic [XLEN-1:0] epc(int k);
    return epc_o[k*XLEN-1 -: XLEN];
  endfunction
  function automatic logic [XLEN-1:0] eps(int k);
    return eps_o[(k-1)*XLEN-1 -: XLEN];
  endfunction

  task automatic check(string req, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  // drive one request at a falling edge; it is sampled at the next rising edge
  task automatic issue(logic ev, logic dv, logic [XLEN-1:0] pc, logic [XLEN-1:0] ps,
                       logic [CW-1:0] c, logic [1:0] asrc, logic [DCW-1:0] dc);
    @(negedge clk);
    exc_valid = ev; dbg_valid = dv; cur_pc = pc; ps_in = ps;
    exc_cause_i = c; exc_addr_src = asrc; dbg_cause_i = dc;
    @(negedge clk);
    exc_valid = 1'b0; dbg_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "vec_valid", XLEN'(vec_valid), 0);
    check("R1", "vec_sel", XLEN'(vec_sel), 0);
    check("R1", "ps_out", ps_out, 0);
    check("R1", "epc1", epc(1), 0);
    check("R1", "depc", depc_o, 0);
    check("R1", "eps6", eps(LVL), 0);
    check("R1", "causes", XLEN'({exccause_o, debugcause_o}), 0);
    check("R1", "excvaddr", excvaddr_o, 0);
  endtask

  task automatic t_kernel();
    issue(1'b1, 1'b0, 32'h0000_1000, 32'h0000_0100, 6'd5, 2'd0, 6'd0);
    check("R2", "vec_sel kernel", XLEN'(vec_sel), 32'h1);
    check("R2", "epc1", epc(1), 32'h0000_1000);
    check("R5", "exccause", XLEN'(exccause_o), 5);
    check("R5", "ps_out", ps_out, 32'h0000_0110);
    check("R6", "excvaddr kept", excvaddr_o, 0);
    check("R10", "vec_valid pulse", XLEN'(vec_valid), 1);
    @(negedge clk);
    check("R10", "vec_valid drops", XLEN'(vec_valid), 0);
    check("R10", "ps_out holds", ps_out, 32'h0000_0110);
  endtask

  task automatic t_user();
    data_addr = 32'hDEAD_0000;
    issue(1'b1, 1'b0, 32'h0000_2000, 32'h0000_0020, 6'd9, 2'd2, 6'd0);
    check("R3", "vec_sel user", XLEN'(vec_sel), 32'h2);
    check("R3", "epc1", epc(1), 32'h0000_2000);
    check("R6", "excvaddr data", excvaddr_o, 32'hDEAD_0000);
    check("R5", "ps_out", ps_out, 32'h0000_0030);
  endtask

  task automatic t_fetch();
    fetch_addr = 32'h0000_3004;
    issue(1'b1, 1'b0, 32'h0000_3000, 32'h0, 6'd12, 2'd1, 6'd0);
    check("R6", "excvaddr fetch", excvaddr_o, 32'h0000_3004);
    check("R2", "epc1", epc(1), 32'h0000_3000);
  endtask

  task automatic t_double();
    issue(1'b1, 1'b0, 32'h0000_4000, 32'h0000_0010, 6'd3, 2'd3, 6'd0);
    check("R4", "vec_sel double", XLEN'(vec_sel), 32'h4);
    check("R4", "depc", depc_o, 32'h0000_4000);
    check("R4", "epc1 unchanged", epc(1), 32'h0000_3000);
    check("R5", "exccause", XLEN'(exccause_o), 3);
    check("R6", "excvaddr kept (src 3)", excvaddr_o, 32'h0000_3004);
  endtask

  task automatic t_debug();
    issue(1'b0, 1'b1, 32'h0000_5000, 32'h0000_0023, 6'd0, 2'd0, 6'h11);
    check("R8", "vec_sel debug", XLEN'(vec_sel), 32'h8);
    check("R8", "debugcause", XLEN'(debugcause_o), 32'h11);
    check("R8", "epc[L]", epc(LVL), 32'h0000_5000);
    check("R8", "eps[L]", eps(LVL), 32'h0000_0023);
    check("R8", "ps_out", ps_out, 32'h0000_0036);
    check("R8", "exccause unchanged", XLEN'(exccause_o), 3);
    // boundary: level one below the debug level is still taken
    issue(1'b0, 1'b1, 32'h0000_5100, 32'h0000_0005, 6'd0, 2'd0, 6'h12);
    check("R7", "level L-1 taken", XLEN'(vec_sel), 32'h8);
    check("R8", "ps_out L-1", ps_out, 32'h0000_0016);
  endtask

  task automatic t_masked();
    issue(1'b0, 1'b1, 32'h0000_6000, 32'h0000_0006, 6'd0, 2'd0, 6'h2A);
    check("R7", "equal level: no pulse", XLEN'(vec_valid), 0);
    check("R7", "debugcause holds", XLEN'(debugcause_o), 32'h12);
    check("R7", "ps_out holds", ps_out, 32'h0000_0016);
    check("R7", "epc[L] holds", epc(LVL), 32'h0000_5100);
    issue(1'b0, 1'b1, 32'h0000_6100, 32'h0000_0009, 6'd0, 2'd0, 6'h2B);
    check("R7", "higher level: no pulse", XLEN'(vec_valid), 0);
    check("R7", "eps[L] holds", eps(LVL), 32'h0000_0005);
  endtask

  task automatic t_both();
    fetch_addr = 32'h0000_7777;
    issue(1'b1, 1'b1, 32'h0000_7000, 32'h0000_0000, 6'd21, 2'd1, 6'h05);
    check("R9", "debug wins", XLEN'(vec_sel), 32'h8);
    check("R9", "exccause untouched", XLEN'(exccause_o), 3);
    check("R9", "epc1 untouched", epc(1), 32'h0000_3000);
    check("R9", "excvaddr untouched", excvaddr_o, 32'h0000_3004);
    check("R9", "epc[L]", epc(LVL), 32'h0000_7000);
    issue(1'b1, 1'b1, 32'h0000_8000, 32'h0000_0007, 6'd22, 2'd0, 6'h06);
    check("R9", "gated debug: kernel", XLEN'(vec_sel), 32'h1);
    check("R9", "gated debug: exccause", XLEN'(exccause_o), 22);
    check("R9", "gated debug: ps_out", ps_out, 32'h0000_0017);
    check("R9", "gated debug: debugcause", XLEN'(debugcause_o), 32'h05);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_kernel();
    t_user();
    t_fetch();
    t_double();
    t_debug();
    t_masked();
    t_both();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule